// File: doc/BRIEF.md
# Half-Duplex Programming Link Master

This block drives a two-wire programming link toward a target device. It has one bidirectional DATA line, seen here as an output enable, an output value and an input, and one CLOCK output that the block generates itself. Every transfer is a 12-bit frame. The frame carries a low start bit, one byte sent least significant bit first, an even parity bit and two high stop bits. The block drives DATA on falling CLOCK edges and samples it on rising CLOCK edges.

The host uses valid/ready handshakes to pass bytes in either direction. It also raises level requests to bring the link up, to close it down and to send an idle break frame. The block handles the link itself:
- It switches the direction of the shared line, with a full-clock turnaround before it drives.
- When it releases the line, it waits for the target's pull-up before it samples.
- It runs a timed entry sequence that ends with two break frames, in one of two variants.
- It runs an orderly exit sequence.

A programmable divider sets the CLOCK rate: each CLOCK half period lasts `div` system cycles, and a value of 0 counts as 1. Receive waits are bounded by a timeout. When the timeout expires, the block sets a sticky error flag and releases DATA.

Top module: `prog_link_master`

## Requirements
- R1: A transmitted frame is seen at rising CLOCK edges in this order: a 0 start bit, data bits 0 through 7, the parity bit, then two 1 stop bits.
- R2: The parity bit makes the total number of ones across the eight data bits and the parity bit even.
- R3: While DATA and CLOCK are both driven, `data_out` changes only in the cycle in which `link_clk` falls.
- R4: In receive mode, the block ignores high samples until it samples DATA low on a rising edge. It discards that start bit, shifts in the next 11 bits, and returns bits 0..7 of them on `rx_data` with a one-cycle `rx_valid` pulse. The parity and stop bits are dropped.
- R5: Before it drives DATA after receiving, the block waits for at least one rising and one falling CLOCK edge. It then turns the output on at a falling edge with `data_out` = 1.
- R6: On a switch to receive, the block first releases DATA, then waits until `data_in` reads high before it looks for a start bit. A low line during that wait is not taken as a start bit.
- R7: A break is 12 rising CLOCK edges with DATA held high. The entry sequence ends with two such breaks: 25 rising edges, with no low sample, pass between the start of CLOCK and the first `tx_ready`.
- R8: Entry with `en_mode` = 0 drives DATA low for `LOW_CYC` cycles and then high for `HIGH_CYC` cycles, and only then starts CLOCK. With `en_mode` = 1 the low phase is skipped. In both variants `hold_reset` rises when entry starts.
- R9: An exit request is taken only once any frame in progress has finished. The block stops and releases CLOCK and releases DATA, and it lowers `hold_reset` one cycle later.
- R10: If no frame completes within `TO_CYC` cycles of a receive wait starting, the block sets `err`, releases DATA and returns to idle. `err` stays set until the next entry request.
- R11: `tx_ready` is high only when the link is idle in transmit mode with DATA driven high. A transmit or break request is taken only on a cycle where `tx_ready` is high, and requests made while the link is down have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div | input | DIV_W | CLOCK half period in system cycles (0 treated as 1) |
| en_req | input | 1 | Level request to bring the link up (taken while down) |
| en_mode | input | 1 | Entry variant: 0 = low pulse then high, 1 = high only |
| dis_req | input | 1 | Level request to close the link (taken when idle) |
| brk_req | input | 1 | Break request, accepted like a transmit byte |
| tx_valid | input | 1 | Transmit byte valid |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit or break request accepted this cycle |
| rx_req | input | 1 | Level request to receive a byte |
| rx_valid | output | 1 | One-cycle pulse, received byte available |
| rx_data | output | 8 | Received byte |
| err | output | 1 | Sticky receive-timeout flag |
| link_clk | output | 1 | CLOCK line value |
| link_clk_oe | output | 1 | CLOCK line output enable |
| data_oe | output | 1 | DATA line output enable |
| data_out | output | 1 | DATA line driven value |
| data_in | input | 1 | DATA line sampled value |
| hold_reset | output | 1 | Holds the target in reset while the link is up |

## Verification
Some results arrive a fixed number of cycles after a request, and the bench counts those cycles exactly:
- The entry low and high phases last exactly `LOW_CYC` and `HIGH_CYC` cycles.
- `hold_reset` falls exactly one cycle after DATA and CLOCK are released.
- A timeout shows a few cycles past `TO_CYC`.

Bit-level results are due only on rising CLOCK edges, because DATA moves only at the preceding falling edge. The bench model of the target therefore samples the line on the CLOCK rise and drives it just after each CLOCK fall. Handshake outputs are polled at the falling system edge, half a cycle away from the edge that updates them.

// File: rtl/prog_link_master.sv
module prog_link_master #(
  parameter int DIV_W    = 8,
  parameter int LOW_CYC  = 200000,
  parameter int HIGH_CYC = 200,
  parameter int TO_CYC   = 2000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             en_req,
  input  logic             en_mode,
  input  logic             dis_req,
  input  logic             brk_req,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  input  logic             rx_req,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             err,
  output logic             link_clk,
  output logic             link_clk_oe,
  output logic             data_oe,
  output logic             data_out,
  input  logic             data_in,
  output logic             hold_reset
);
  localparam int TMAX = (LOW_CYC > TO_CYC) ? ((LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC)
                                           : ((TO_CYC > HIGH_CYC) ? TO_CYC : HIGH_CYC);
  localparam int TW = $clog2(TMAX + 1);

  typedef enum logic [3:0] {
    S_OFF, S_LOW, S_HIGH, S_IDLE, S_TURN, S_TX, S_REL, S_RX, S_EXIT
  } state_t;

  state_t           st;
  logic [DIV_W-1:0] dcnt;
  logic [TW-1:0]    tmr;
  logic [11:0]      sh;
  logic [3:0]       bits;
  logic             sclk, brk_left, sending, started, turn_seen;

  wire run  = (st == S_IDLE) || (st == S_TURN) || (st == S_TX) || (st == S_REL) || (st == S_RX);
  wire tick = run && (dcnt == '0);
  wire rise = tick && !sclk;
  wire fall = tick && sclk;
  wire [DIV_W-1:0] divm1 = (div == '0) ? '0 : div - 1'b1;
  wire [11:0] frame = {2'b11, ^tx_data, tx_data, 1'b0};

  assign tx_ready = (st == S_IDLE) && sending;
  assign link_clk = sclk && link_clk_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      dcnt <= divm1;
      sclk <= 1'b0;
    end else if (dcnt == '0) begin
      dcnt <= divm1;
      sclk <= !sclk;
    end else begin
      dcnt <= dcnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF; tmr <= '0; sh <= '0; bits <= '0;
      brk_left <= 1'b0; sending <= 1'b0; started <= 1'b0; turn_seen <= 1'b0;
      data_oe <= 1'b0; data_out <= 1'b0; link_clk_oe <= 1'b0; hold_reset <= 1'b0;
      err <= 1'b0; rx_valid <= 1'b0; rx_data <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        S_OFF: if (en_req) begin
          hold_reset <= 1'b1;
          err        <= 1'b0;
          data_oe    <= 1'b1;
          data_out   <= en_mode;
          tmr        <= en_mode ? TW'(HIGH_CYC - 1) : TW'(LOW_CYC - 1);
          st         <= en_mode ? S_HIGH : S_LOW;
        end
        S_LOW: if (tmr == '0) begin
          data_out <= 1'b1;
          tmr      <= TW'(HIGH_CYC - 1);
          st       <= S_HIGH;
        end else tmr <= tmr - 1'b1;
        S_HIGH: if (tmr == '0) begin
          sh <= 12'hFFF; bits <= 4'd12; brk_left <= 1'b1;
          sending <= 1'b1; link_clk_oe <= 1'b1;
          st <= S_TX;
        end else tmr <= tmr - 1'b1;
        S_IDLE: begin
          if (dis_req) begin
            data_oe <= 1'b0; data_out <= 1'b0; link_clk_oe <= 1'b0; sending <= 1'b0;
            st <= S_EXIT;
          end else if (tx_valid || brk_req) begin
            if (sending) begin
              sh <= brk_req ? 12'hFFF : frame;
              bits <= 4'd12;
              st <= S_TX;
            end else begin
              turn_seen <= 1'b0;
              st <= S_TURN;
            end
          end else if (rx_req) begin
            tmr <= TW'(TO_CYC - 1);
            if (sending) begin
              data_oe <= 1'b0; sending <= 1'b0;
              st <= S_REL;
            end else begin
              started <= 1'b0; bits <= 4'd11;
              st <= S_RX;
            end
          end
        end
        S_TURN: begin
          if (rise) turn_seen <= 1'b1;
          if (fall && turn_seen) begin
            data_oe <= 1'b1; data_out <= 1'b1; sending <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_TX: begin
          if (fall && bits != 4'd0) begin
            data_out <= sh[0];
            sh <= {1'b1, sh[11:1]};
            bits <= bits - 1'b1;
          end else if (rise && bits == 4'd0) begin
            if (brk_left) begin
              brk_left <= 1'b0; sh <= 12'hFFF; bits <= 4'd12;
            end else st <= S_IDLE;
          end
        end
        S_REL: begin
          if (data_in) st <= S_IDLE;
          else if (tmr == '0) begin err <= 1'b1; st <= S_IDLE; end
          else tmr <= tmr - 1'b1;
        end
        S_RX: begin
          if (rise && started) begin
            sh <= {data_in, sh[11:1]};
            bits <= bits - 1'b1;
            if (bits == 4'd1) begin
              rx_valid <= 1'b1;
              rx_data  <= sh[9:2];
              tmr      <= TW'(TO_CYC - 1);
              st       <= S_IDLE;
            end
          end else if (tmr == '0) begin
            err <= 1'b1; st <= S_IDLE;
          end else begin
            tmr <= tmr - 1'b1;
            if (rise && !data_in) started <= 1'b1;
          end
        end
        S_EXIT: begin
          hold_reset <= 1'b0;
          st <= S_OFF;
        end
        default: st <= S_OFF;
      endcase
    end
  end
endmodule

module prog_link_master_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_ready,
  input logic err,
  input logic link_clk,
  input logic link_clk_oe,
  input logic data_oe,
  input logic data_out,
  input logic hold_reset
);
  assert_drive_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_clk_oe && $past(link_clk_oe) && data_oe && $past(data_oe) && data_out != $past(data_out))
      |-> ($past(link_clk) && !link_clk));

  assert_turn_drives_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(data_oe) && link_clk_oe) |-> (data_out && !link_clk));

  assert_exit_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_reset) |-> (!data_oe && !link_clk_oe && !$past(data_oe) && !$past(link_clk_oe)));

  assert_timeout_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !data_oe);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err) && $past(hold_reset)) |-> err);

  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (data_oe && data_out && link_clk_oe && hold_reset));
endmodule

bind prog_link_master prog_link_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .err(err), .link_clk(link_clk),
  .link_clk_oe(link_clk_oe), .data_oe(data_oe), .data_out(data_out), .hold_reset(hold_reset)
);

// File: tb/prog_link_master_tb.sv
`timescale 1ns/1ps
module prog_link_master_tb;
  localparam int LOW = 40, HIGH = 10, TO = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] div = 8'd3;
  logic en_req = 0, en_mode = 0, dis_req = 0, brk_req = 0, tx_valid = 0, rx_req = 0;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_valid, err, link_clk, link_clk_oe, data_oe, data_out, hold_reset;
  logic [7:0] rx_data;
  logic tgt_drv = 1'b1;
  wire line = data_oe ? data_out : tgt_drv;

  prog_link_master #(.DIV_W(8), .LOW_CYC(LOW), .HIGH_CYC(HIGH), .TO_CYC(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .div(div), .en_req(en_req), .en_mode(en_mode),
    .dis_req(dis_req), .brk_req(brk_req), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_req(rx_req), .rx_valid(rx_valid), .rx_data(rx_data),
    .err(err), .link_clk(link_clk), .link_clk_oe(link_clk_oe), .data_oe(data_oe),
    .data_out(data_out), .data_in(line), .hold_reset(hold_reset));

  always #2.5 clk = !clk;

  int n_chk = 0, n_bad = 0, cyc = 0, rise_cnt = 0, low_cnt = 0, viol = 0;
  logic p_oe = 0, p_ck = 0, p_lk = 0, p_do = 0;

  always @(posedge link_clk) begin
    rise_cnt++;
    if (!line) low_cnt++;
  end

  always @(negedge clk) begin
    cyc++;
    if (data_oe && p_oe && link_clk_oe && p_ck && data_out != p_do && !(p_lk && !link_clk)) viol++;
    p_oe = data_oe; p_ck = link_clk_oe; p_lk = link_clk; p_do = data_out;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    int w = 0;
    while (!tx_ready && w < 2000) begin @(negedge clk); w++; end
  endtask

  task automatic capture(output logic [11:0] cap);
    int w = 0;
    do begin @(posedge link_clk); w++; end while (line != 1'b0 && w < 100);
    cap[0] = line;
    for (int i = 1; i < 12; i++) begin @(posedge link_clk); cap[i] = line; end
  endtask

  task automatic enter(input logic mode);
    int lo = 0, hi = 0, w = 0, r0, l0;
    @(negedge clk); en_mode = mode; en_req = 1;
    @(negedge clk); en_req = 0;
    while (!link_clk_oe && w < 1000) begin
      if (data_oe && !data_out) lo++;
      if (data_oe && data_out) hi++;
      @(negedge clk); w++;
    end
    chk(lo == (mode ? 0 : LOW), "R8 low phase cycles", lo, mode ? 0 : LOW);
    chk(hi == HIGH, "R8 high phase cycles", hi, HIGH);
    chk(hold_reset == 1'b1, "R8 hold_reset during entry", hold_reset, 1);
    chk(err == 1'b0, "R10 err cleared by entry", err, 0);
    r0 = rise_cnt; l0 = low_cnt;
    wait_ready();
    chk(rise_cnt - r0 == 25, "R7 entry break rises", rise_cnt - r0, 25);
    chk(low_cnt == l0, "R7 entry breaks stay high", low_cnt - l0, 0);
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    logic [11:0] cap, exp;
    exp = {2'b11, ^b, b, 1'b0};
    @(negedge clk); tx_data = b; tx_valid = 1;
    wait_ready();
    @(negedge clk); tx_valid = 0;
    capture(cap);
    chk(cap == exp, tag, cap, exp);
    chk(^cap[9:1] == 1'b0, "R2 even parity on line", ^cap[9:1], 0);
  endtask

  task automatic send_break();
    int r0, l0;
    @(negedge clk); brk_req = 1;
    wait_ready();
    @(negedge clk); brk_req = 0;
    r0 = rise_cnt; l0 = low_cnt;
    wait_ready();
    chk(rise_cnt - r0 >= 11 && rise_cnt - r0 <= 12, "R7 break length in rises", rise_cnt - r0, 12);
    chk(low_cnt == l0, "R7 break carries no low bit", low_cnt - l0, 0);
  endtask

  task automatic recv_byte(input logic [7:0] b, input bit pre_low, input string tag);
    logic [11:0] fr;
    int w = 0;
    bit got = 0;
    fr = {2'b11, ^b, b, 1'b0};
    @(negedge clk); if (pre_low) tgt_drv = 0; rx_req = 1;
    while (data_oe && w < 500) begin @(negedge clk); w++; end
    if (pre_low) begin
      repeat (20) begin
        @(negedge clk);
        if (rx_valid) got = 1;
      end
      chk(!got, "R6 no byte while line held low", got, 0);
      tgt_drv = 1;
    end
    repeat (2) @(negedge link_clk);
    for (int i = 0; i < 12; i++) begin @(negedge link_clk); #1 tgt_drv = fr[i]; end
    w = 0;
    while (!rx_valid && w < 100) begin @(negedge clk); w++; end
    chk(rx_valid && rx_data == b, tag, rx_data, b);
    rx_req = 0;
  endtask

  task automatic timeout_case();
    int w = 0;
    @(negedge clk); rx_req = 1;
    while (!err && w < 1000) begin @(negedge clk); w++; end
    rx_req = 0;
    chk(w >= TO && w <= TO + 10, "R10 timeout delay", w, TO);
    chk(err && !data_oe, "R10 err set and DATA released", {err, data_oe}, 2);
    send_byte(8'h11, "R1 frame after timeout");
    chk(err == 1'b1, "R10 err sticky", err, 1);
  endtask

  task automatic turnaround_case();
    int r0, w = 0;
    r0 = rise_cnt;
    @(negedge clk); tx_data = 8'h5A; tx_valid = 1;
    while (!data_oe && w < 500) begin @(negedge clk); w++; end
    chk(rise_cnt - r0 >= 1, "R5 full clock before driving", rise_cnt - r0, 1);
    chk(data_out == 1'b1, "R5 line driven high first", data_out, 1);
    tx_valid = 0;
    send_byte(8'h5A, "R1 frame after turnaround 5A");
  endtask

  task automatic exit_case();
    logic [11:0] cap, exp;
    int oe_off = -1, hold_off = -1, w = 0;
    exp = {2'b11, ^8'h96, 8'h96, 1'b0};
    @(negedge clk); tx_data = 8'h96; tx_valid = 1;
    wait_ready();
    @(negedge clk); tx_valid = 0; dis_req = 1;
    capture(cap);
    chk(cap == exp, "R9 pending frame completes before exit", cap, exp);
    while (hold_reset && w < 500) begin
      @(negedge clk); w++;
      if (!data_oe && !link_clk_oe && oe_off < 0) oe_off = w;
    end
    hold_off = w;
    dis_req = 0;
    chk(hold_off == oe_off + 1, "R9 hold_reset released one cycle after lines", hold_off, oe_off + 1);
    chk(!link_clk && !data_oe && !link_clk_oe, "R9 lines released", {link_clk, data_oe, link_clk_oe}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!tx_ready && !data_oe && !hold_reset && !err && !link_clk, "R11 reset state",
        {tx_ready, data_oe, hold_reset, err, link_clk}, 0);
    tx_valid = 1; tx_data = 8'hAA;
    repeat (5) @(negedge clk);
    chk(!tx_ready && !data_oe, "R11 transmit ignored while link down", {tx_ready, data_oe}, 0);
    tx_valid = 0;

    enter(1'b0);
    send_byte(8'h00, "R1 frame 00");
    send_byte(8'hFF, "R1 frame FF");
    send_byte(8'hA5, "R1 frame A5");
    send_byte(8'h01, "R2 frame 01 odd weight");
    send_break();
    recv_byte(8'h3C, 1'b0, "R4 received 3C");
    recv_byte(8'hC3, 1'b0, "R4 back-to-back receive C3");
    turnaround_case();
    recv_byte(8'h81, 1'b1, "R6 received 81 after slow release");
    timeout_case();
    exit_case();
    enter(1'b1);
    send_byte(8'h7E, "R1 frame 7E after second entry");
    chk(viol == 0, "R3 DATA moved off a falling CLOCK edge", viol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule